// File: doc/BRIEF.md
# Dual-View General Register File

This block is a general-purpose integer register file with sixty-four 64-bit entries. It has two combinational read ports and one synchronous write port. Every port carries its own view-select bit, so one cycle can mix the two ways of reaching the same storage.

The wide view reaches all 64 entries at full width. Its highest index is a hard-wired zero register: reads of it return zero, and writes to it are dropped. The narrow view is a 32-bit window onto the first sixteen entries. A narrow read returns the low half of the entry, zero-extended. A narrow write stores its 32-bit value sign-extended to 64 bits. Code working in 32-bit mode and code working in 64-bit mode therefore see a single coherent set of registers.

A pipeline would use it as its architectural integer file. Decode supplies the indices and the view bits. Forwarding, if any, lives outside this block.

Top module: `dual_view_regfile`

## Requirements
- R1: A synchronous active-high reset clears every entry, so every wide read returns zero on the first cycle after reset is released.
- R2: A wide write (view bit 0) of a 64-bit value to index k < 63 makes every wide read of k return that exact value from the next cycle on.
- R3: A wide read of index 63 always returns zero, whatever was written there.
- R4: A write to wide index 63 changes no stored entry.
- R5: In the narrow view (view bit 1), only index bits [3:0] are used and bits [5:4] are ignored, so narrow index n reaches wide entry n[3:0].
- R6: A narrow read returns bits [31:0] of the entry in result bits [31:0], with bits [63:32] of the result zero.
- R7: A narrow write stores wr_data[31:0] sign-extended to 64 bits (bit 31 copied into bits [63:32]), and wr_data[63:32] is ignored.
- R8: A read of the entry being written in the same cycle returns the old value. The new value appears on the cycle after the clock edge.
- R9: The two read ports are independent: each has its own index and view bit, and both can address the same or different entries in one cycle.
- R10: While wr_en is 0, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_narrow | input | 1 | Write view: 0 wide, 1 narrow |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write value (low 32 bits used in narrow view) |
| ra_narrow | input | 1 | Read port A view: 0 wide, 1 narrow |
| ra_idx | input | 6 | Read port A index |
| ra_data | output | 64 | Read port A value |
| rb_narrow | input | 1 | Read port B view: 0 wide, 1 narrow |
| rb_idx | input | 6 | Read port B index |
| rb_data | output | 64 | Read port B value |

## Verification
Reads are combinational, so a corrupted entry is visible on a read port as soon as that index is presented. The bench reads back every entry it touched, and also neighbouring entries, one cycle after each write. Several faults show up in the upper half of a wide read of an entry written through the narrow view: a wrong extension, a lost mask or an index that aliases elsewhere. A write that leaks into entry 63, or into a narrow alias above 15, shows up when the untouched entries are read back on the following cycle.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    localparam int XLEN          = 64;
    localparam int NUM_REGS      = 64;
    localparam int IDX_W         = $clog2(NUM_REGS);
    localparam int NARROW_W      = 32;
    localparam int NARROW_REGS   = 16;
    localparam int NARROW_IDX_W  = $clog2(NARROW_REGS);
    localparam int NUM_RD        = 2;

    typedef enum logic {
        VIEW_WIDE   = 1'b0,
        VIEW_NARROW = 1'b1
    } view_e;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        view_e view;
        idx_t  idx;
    } rd_req_t;

    typedef struct packed {
        logic  en;
        view_e view;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    localparam idx_t ZERO_IDX = idx_t'(NUM_REGS - 1);

    // Map a view-relative index onto a storage index.
    function automatic idx_t phys_index(view_e view, idx_t idx);
        if (view == VIEW_NARROW)
            return idx_t'(idx[NARROW_IDX_W-1:0]);
        return idx;
    endfunction

    function automatic word_t narrow_zext(word_t value);
        return word_t'(value[NARROW_W-1:0]);
    endfunction

    function automatic word_t narrow_sext(word_t value);
        return {{(XLEN-NARROW_W){value[NARROW_W-1]}}, value[NARROW_W-1:0]};
    endfunction

endpackage

// File: rtl/gprf_storage.sv
module gprf_storage
    import gprf_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int WIDTH  = XLEN,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] entries [N_REGS]
);

    logic [WIDTH-1:0] mem [N_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < N_REGS; i++) begin
            entries[i] = mem[i];
        end
    end

endmodule

// File: rtl/gprf_write_port.sv
module gprf_write_port
    import gprf_pkg::*;
(
    input  wr_req_t req,
    output logic    we,
    output idx_t    waddr,
    output word_t   wdata
);

    idx_t target;

    always_comb begin
        target = phys_index(req.view, req.idx);
        waddr  = target;
        // Stores aimed at the hard-wired zero entry are dropped.
        we     = req.en && (target != ZERO_IDX);
        wdata  = (req.view == VIEW_NARROW) ? narrow_sext(req.data) : req.data;
    end

endmodule

// File: rtl/gprf_read_port.sv
module gprf_read_port
    import gprf_pkg::*;
(
    input  rd_req_t req,
    input  word_t   entries [NUM_REGS],
    output word_t   data
);

    idx_t  target;
    word_t raw;

    always_comb begin
        target = phys_index(req.view, req.idx);
        raw    = entries[target];
        if (target == ZERO_IDX) begin
            data = '0;
        end else if (req.view == VIEW_NARROW) begin
            data = narrow_zext(raw);
        end else begin
            data = raw;
        end
    end

endmodule

// File: rtl/dual_view_regfile.sv
module dual_view_regfile
    import gprf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_narrow,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            ra_narrow,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic            rb_narrow,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [XLEN-1:0] rb_data
);

    wr_req_t wreq;
    rd_req_t rreq [NUM_RD];
    word_t   rdata [NUM_RD];
    word_t   entries [NUM_REGS];
    logic    st_we;
    idx_t    st_waddr;
    word_t   st_wdata;

    always_comb begin
        wreq.en   = wr_en;
        wreq.view = view_e'(wr_narrow);
        wreq.idx  = wr_idx;
        wreq.data = wr_data;
        rreq[0].view = view_e'(ra_narrow);
        rreq[0].idx  = ra_idx;
        rreq[1].view = view_e'(rb_narrow);
        rreq[1].idx  = rb_idx;
    end

    gprf_write_port u_wport (
        .req   (wreq),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata)
    );

    gprf_storage #(
        .N_REGS (NUM_REGS),
        .WIDTH  (XLEN)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (st_wdata),
        .entries (entries)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gprf_read_port u_rport (
            .req     (rreq[p]),
            .entries (entries),
            .data    (rdata[p])
        );
    end

    assign ra_data = rdata[0];
    assign rb_data = rdata[1];

endmodule

// File: rtl/gprf_checker.sv
module gprf_checker
    import gprf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_narrow,
    input logic [IDX_W-1:0] wr_idx,
    input logic [XLEN-1:0]  wr_data,
    input logic             ra_narrow,
    input logic [IDX_W-1:0] ra_idx,
    input logic [XLEN-1:0]  ra_data,
    input logic             rb_narrow,
    input logic [IDX_W-1:0] rb_idx,
    input logic [XLEN-1:0]  rb_data
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ra_narrow -> ra_data == '0) && (!rb_narrow -> rb_data == '0));

    // R3
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
        (!ra_narrow && ra_idx == ZERO_IDX) |-> ra_data == '0);

    // R3
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!rb_narrow && rb_idx == ZERO_IDX) |-> rb_data == '0);

    // R6
    narrow_upper_a_chk: assert property (@(posedge clk) disable iff (rst)
        ra_narrow |-> ra_data[XLEN-1:NARROW_W] == '0);

    // R6
    narrow_upper_b_chk: assert property (@(posedge clk) disable iff (rst)
        rb_narrow |-> rb_data[XLEN-1:NARROW_W] == '0);

    // R2
    wide_write_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_narrow && wr_idx != ZERO_IDX) |=>
        (!(!ra_narrow && ra_idx == $past(wr_idx)) || ra_data == $past(wr_data)));

    // R7
    narrow_write_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_narrow) |=>
        (!(!ra_narrow && ra_idx == idx_t'($past(wr_idx[NARROW_IDX_W-1:0])))
         || ra_data == narrow_sext($past(wr_data))));

endmodule

bind dual_view_regfile gprf_checker u_gprf_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_narrow (wr_narrow),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ra_narrow (ra_narrow),
    .ra_idx    (ra_idx),
    .ra_data   (ra_data),
    .rb_narrow (rb_narrow),
    .rb_idx    (rb_idx),
    .rb_data   (rb_data)
);

// File: tb/test_dual_view_regfile.sv
module test_dual_view_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_narrow;
    logic [5:0]  wr_idx;
    logic [63:0] wr_data;
    logic        ra_narrow, rb_narrow;
    logic [5:0]  ra_idx, rb_idx;
    logic [63:0] ra_data, rb_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_view_regfile i_dual_view_regfile (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_narrow(wr_narrow), .wr_idx(wr_idx), .wr_data(wr_data),
        .ra_narrow(ra_narrow), .ra_idx(ra_idx), .ra_data(ra_data),
        .rb_narrow(rb_narrow), .rb_idx(rb_idx), .rb_data(rb_data)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write one value; returns at the falling edge after the clock edge.
    task automatic wr(logic narrow, logic [5:0] idx, logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_narrow = narrow; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_a(logic narrow, logic [5:0] idx, logic [63:0] exp, string tag);
        ra_narrow = narrow; ra_idx = idx; #2;
        chk(tag, ra_data, exp);
    endtask

    task automatic rd_b(logic narrow, logic [5:0] idx, logic [63:0] exp, string tag);
        rb_narrow = narrow; rb_idx = idx; #2;
        chk(tag, rb_data, exp);
    endtask

    task automatic t_reset;
        rd_a(1'b0, 6'd0,  64'd0, "R1 entry0 after reset");
        rd_b(1'b0, 6'd62, 64'd0, "R1 entry62 after reset");
        rd_a(1'b0, 6'd31, 64'd0, "R1 entry31 after reset");
    endtask

    task automatic t_wide;
        wr(1'b0, 6'd5,  64'hA5A5_0123_4567_89AB);
        wr(1'b0, 6'd62, 64'hFEDC_BA98_7654_3210);
        rd_a(1'b0, 6'd5,  64'hA5A5_0123_4567_89AB, "R2 wide entry5");
        rd_b(1'b0, 6'd62, 64'hFEDC_BA98_7654_3210, "R2 wide entry62");
        // R9: same entry on both ports, different views
        rd_a(1'b0, 6'd5, 64'hA5A5_0123_4567_89AB, "R9 port A wide entry5");
        rd_b(1'b1, 6'd5, 64'h0000_0000_4567_89AB, "R9 port B narrow entry5");
    endtask

    task automatic t_zero;
        wr(1'b0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_a(1'b0, 6'd63, 64'd0, "R3 entry63 reads zero");
        rd_b(1'b0, 6'd62, 64'hFEDC_BA98_7654_3210, "R4 entry62 unchanged");
        rd_a(1'b0, 6'd5,  64'hA5A5_0123_4567_89AB, "R4 entry5 unchanged");
        rd_b(1'b1, 6'd15, 64'd0, "R4 narrow entry15 unchanged");
    endtask

    task automatic t_narrow_read;
        wr(1'b0, 6'd3, 64'hDEAD_BEEF_8000_0001);
        rd_a(1'b1, 6'd3,  64'h0000_0000_8000_0001, "R6 narrow read zero-extends");
        rd_b(1'b1, 6'h33, 64'h0000_0000_8000_0001, "R5 narrow idx bits 5:4 ignored");
    endtask

    task automatic t_narrow_write;
        wr(1'b1, 6'd7, 64'h1234_5678_8765_4321);
        rd_a(1'b0, 6'd7, 64'hFFFF_FFFF_8765_4321, "R7 narrow write sign-extends");
        wr(1'b1, 6'd40, 64'hFFFF_0000_7000_0000);
        rd_a(1'b0, 6'd8,  64'h0000_0000_7000_0000, "R7 positive sign-extend, high data ignored");
        rd_b(1'b0, 6'd40, 64'd0, "R5 narrow write idx 40 lands on entry8 not 40");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_narrow = 1'b0; wr_idx = 6'd10; wr_data = 64'h0BAD_F00D_CAFE_0001;
        rd_a(1'b0, 6'd10, 64'd0, "R8 old value before edge");
        @(negedge clk);
        wr_en = 1'b0;
        rd_a(1'b0, 6'd10, 64'h0BAD_F00D_CAFE_0001, "R8 new value after edge");
    endtask

    task automatic t_wren_low;
        @(negedge clk);
        wr_en = 1'b0; wr_narrow = 1'b0; wr_idx = 6'd5; wr_data = 64'h1111_2222_3333_4444;
        @(negedge clk);
        @(negedge clk);
        rd_a(1'b0, 6'd5, 64'hA5A5_0123_4567_89AB, "R10 no write when disabled");
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_narrow = 1'b0; wr_idx = '0; wr_data = '0;
        ra_narrow = 1'b0; ra_idx = '0; rb_narrow = 1'b0; rb_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wide();
        t_zero();
        t_narrow_read();
        t_narrow_write();
        t_same_cycle();
        t_wren_low();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule